// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar in seven packed-BCD registers: seconds, minutes, hours, date of month, month, a two-digit year and a day-of-week index. A free-running tick input is divided by a parameterised count to produce one advance per second. Each advance ripples carries through seconds, minutes and hours into the date, the month and the year. The day-of-week index steps on every date change.

The hour register carries its own format selector. With bit 7 set, hours count 00 to 23. With bit 7 clear, hours count 12, 01 to 11, and bit 5 marks the afternoon. Month lengths follow the usual table. February gains a 29th day in every year whose two-digit value is a multiple of four. A host port writes any register, one per cycle, and reads any register back combinationally.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read seconds 8'h00, minutes 8'h00, hours 8'h12 (12-hour format, morning), date 8'h01, month 8'h01, year 8'h00 and day of week 8'h00.
- R2: Seconds advance once for every TICKS_PER_SEC pulses on tick_in. A host write to the seconds register clears the sub-second phase, so the next advance comes after a further TICKS_PER_SEC pulses.
- R3: Seconds and minutes count in BCD from 00 to 59, one digit at a time. The low digit carries from 9 into the high digit. A wrap from 59 to 00 advances the next register up.
- R4: With hour bit 7 = 1, hours (bits 5:0, BCD) count 00 to 23. The step from 23 to 00 advances the date.
- R5: With hour bit 7 = 0, bits 4:0 hold the hour in BCD and bit 5 is a PM flag (1 = PM). Hours step 12, 01, ..., 11. The flag toggles on the step from 11 to 12, and the step from 11 PM to 12 AM advances the date.
- R6: The last date is 31 in months 01, 03, 05, 07, 08, 10 and 12, and 30 in months 04, 06, 09 and 11. A date advance past the last date gives 01 and increments the month.
- R7: February ends on 29 when the BCD year is divisible by four (00 included) and on 28 otherwise.
- R8: A month advance past 12 gives 01 and increments the year. Year 99 wraps to 00.
- R9: Day of week steps 0,1,...,6,0 on each date advance.
- R10: When wr_en is high, wr_data is written to the register that wr_addr selects. The addresses are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year and 6 day of week. rd_data shows the register that rd_addr selects in the same cycle, and address 7 reads 8'h00.
- R11: A second boundary that falls in a cycle with wr_en high is discarded, so no register advances in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | Sub-second tick, one pulse per clock |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Register select for writes |
| wr_data | input | 8 | Write value, packed BCD |
| rd_addr | input | 3 | Register select for reads |
| rd_data | output | 8 | Selected register value |

## Verification
On every cycle the assertions check the local transitions: the 59-to-00 wrap, 23-to-00 in 24-hour mode, the PM toggle and the day carry at 11 PM, the day-of-week wrap, February 29 in leap years, the December carry into the year, the clearing of the tick phase, and the blocking of advances by a host write. Only the bench's scenarios can show whole sequences. It sweeps all hour values in both formats, all twelve month lengths for a leap and a non-leap year, and February for all hundred years. It also checks the BCD digit carries over two minutes of seconds and the exact number of ticks per second after a phase reset.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;

   typedef enum logic [2:0] {
      A_SEC   = 3'd0,
      A_MIN   = 3'd1,
      A_HOUR  = 3'd2,
      A_DATE  = 3'd3,
      A_MONTH = 3'd4,
      A_YEAR  = 3'd5,
      A_DOW   = 3'd6
   } reg_addr_e;

   localparam int NUM_REGS = 7;

   // Two-digit BCD increment; low digit carries 9 -> 0 into the high digit.
   function automatic logic [7:0] bcd_incr(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // Value mod 4 of a BCD pair equals (2*tens + ones) mod 4.
   function automatic logic is_leap(input logic [7:0] yr);
      logic [1:0] s;
      s = yr[1:0] + {yr[4], 1'b0};
      return (s == 2'd0);
   endfunction

   function automatic logic [7:0] month_last_day(input logic [7:0] mon, input logic leap);
      case (mon)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_tick_divider.sv
module rtc_tick_divider #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   input  logic clear,
   output logic sec_pulse
);
   if (DIV < 1) begin : g_bad_div
      $error("rtc_tick_divider: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_direct
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n, clear};
      assign sec_pulse = tick_in;
   end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] TERM = CW'(DIV - 1);
      logic [CW-1:0] phase_q;

      assign sec_pulse = tick_in && (phase_q == TERM);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         phase_q <= '0;
         else if (clear)     phase_q <= '0;
         else if (sec_pulse) phase_q <= '0;
         else if (tick_in)   phase_q <= phase_q + 1'b1;
      end

      // R2: after a phase clear the next cycle cannot complete a second
      p_phase_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
         clear |=> !sec_pulse);
   end
endmodule

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap
   import rtc_core_pkg::*;
#(
   parameter logic [7:0] LO  = 8'h00,
   parameter logic [7:0] HI  = 8'h59,
   parameter logic [7:0] RST = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       ld,
   input  logic [7:0] ld_val,
   output logic [7:0] q,
   output logic       carry
);
   if (LO > HI) begin : g_bad_range
      $error("rtc_bcd_wrap: LO above HI");
   end

   assign carry = inc && (q >= HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST;
      else if (ld)    q <= ld_val;
      else if (carry) q <= LO;
      else if (inc)   q <= bcd_incr(q);
   end

   // R3 / R8: counting past the top value returns to the bottom value
   p_wrap_to_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && q == HI) |=> (q == LO));
endmodule

// File: rtl/rtc_hour_unit.sv
module rtc_hour_unit
   import rtc_core_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       ld,
   input  logic [7:0] ld_val,
   output logic [7:0] q,
   output logic       day_carry
);
   localparam logic [7:0] RST_HOUR = 8'h12;  // 12-hour format, 12 AM

   logic       mode24;
   logic       pm;
   logic [7:0] nxt;
   logic [7:0] inc24;
   logic [7:0] inc12;

   assign mode24 = q[7];
   assign pm     = q[5];
   assign inc24  = bcd_incr({2'b00, q[5:0]});
   assign inc12  = bcd_incr({3'b000, q[4:0]});

   always_comb begin
      day_carry = 1'b0;
      if (mode24) begin
         if (q[5:0] >= 6'h23) begin
            nxt       = 8'h80;
            day_carry = inc;
         end else begin
            nxt = {2'b10, inc24[5:0]};
         end
      end else begin
         if (q[4:0] == 5'h11) begin
            nxt       = {2'b00, ~pm, 5'h12};
            day_carry = inc && pm;
         end else if (q[4:0] >= 5'h12) begin
            nxt = {2'b00, pm, 5'h01};
         end else begin
            nxt = {2'b00, pm, inc12[4:0]};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RST_HOUR;
      else if (ld)  q <= ld_val;
      else if (inc) q <= nxt;
   end

   // R4: 23 -> 00 in 24-hour mode carries into the date
   p_h24_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && q == 8'hA3) |=> (q == 8'h80));
   p_h24_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && q == 8'hA3) |-> day_carry);
   // R5: 11 -> 12 flips the PM flag; 11 PM carries into the date
   p_pm_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && !mode24 && q[4:0] == 5'h11) |=> (q[5] != $past(q[5])));
   p_pm_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && q == 8'h31) |-> day_carry);
   p_am_no_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (q == 8'h11) |-> !day_carry);
endmodule

// File: rtl/rtc_calendar_unit.sv
module rtc_calendar_unit
   import rtc_core_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       ld_date,
   input  logic       ld_month,
   input  logic       ld_dow,
   input  logic [7:0] ld_val,
   input  logic [7:0] year,
   output logic [7:0] date,
   output logic [7:0] month,
   output logic [2:0] dow,
   output logic       year_carry
);
   localparam logic [2:0] DOW_LAST = 3'd6;

   logic [7:0] last_day;
   logic       month_end;
   logic       month_wrap;

   assign last_day   = month_last_day(month, is_leap(year));
   assign month_end  = inc && (date >= last_day);
   assign month_wrap = month_end && (month >= 8'h12);
   assign year_carry = month_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         date <= 8'h01;
      else if (ld_date)   date <= ld_val;
      else if (month_end) date <= 8'h01;
      else if (inc)       date <= bcd_incr(date);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          month <= 8'h01;
      else if (ld_month)   month <= ld_val;
      else if (month_wrap) month <= 8'h01;
      else if (month_end)  month <= bcd_incr(month);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dow <= 3'd0;
      else if (ld_dow) dow <= ld_val[2:0];
      else if (inc)    dow <= (dow >= DOW_LAST) ? 3'd0 : dow + 3'd1;
   end

   // R9: day of week wraps 6 -> 0
   p_dow_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld_dow && dow == DOW_LAST) |=> (dow == 3'd0));
   // R7: leap February reaches the 29th
   p_feb_leap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld_date && !ld_month && month == 8'h02 && date == 8'h28 && is_leap(year))
      |=> (date == 8'h29));
   // R8: December 31 carries into the year
   p_year_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && month == 8'h12 && date == 8'h31) |-> year_carry);
   // R6: a 30-day month never shows the 31st after an advance
   p_short_month_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld_date && !ld_month && month == 8'h04 && date == 8'h30)
      |=> (date == 8'h01 && month == 8'h05));
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_core_pkg::*;
#(
   parameter int TICKS_PER_SEC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_in,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [2:0] rd_addr,
   output logic [7:0] rd_data
);
   localparam int AW = 3;

   if (NUM_REGS > (1 << AW)) begin : g_bad_map
      $error("bcd_rtc_core: register map exceeds address space");
   end

   logic [NUM_REGS-1:0] ld_vec;
   logic       sec_pulse, adv;
   logic       c_sec, c_min, c_day, c_year, c_unused;
   logic [7:0] sec_q, min_q, hour_q, date_q, month_q, year_q;
   logic [2:0] dow_q;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
      assign ld_vec[i] = wr_en && (wr_addr == AW'(i));
   end

   assign adv = sec_pulse && !wr_en;

   rtc_tick_divider #(.DIV(TICKS_PER_SEC)) u_div (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
      .clear(ld_vec[A_SEC]), .sec_pulse(sec_pulse));

   rtc_bcd_wrap #(.LO(8'h00), .HI(8'h59), .RST(8'h00)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc(adv), .ld(ld_vec[A_SEC]),
      .ld_val(wr_data), .q(sec_q), .carry(c_sec));

   rtc_bcd_wrap #(.LO(8'h00), .HI(8'h59), .RST(8'h00)) u_min (
      .clk(clk), .rst_n(rst_n), .inc(c_sec), .ld(ld_vec[A_MIN]),
      .ld_val(wr_data), .q(min_q), .carry(c_min));

   rtc_hour_unit u_hour (
      .clk(clk), .rst_n(rst_n), .inc(c_min), .ld(ld_vec[A_HOUR]),
      .ld_val(wr_data), .q(hour_q), .day_carry(c_day));

   rtc_calendar_unit u_cal (
      .clk(clk), .rst_n(rst_n), .inc(c_day),
      .ld_date(ld_vec[A_DATE]), .ld_month(ld_vec[A_MONTH]), .ld_dow(ld_vec[A_DOW]),
      .ld_val(wr_data), .year(year_q),
      .date(date_q), .month(month_q), .dow(dow_q), .year_carry(c_year));

   rtc_bcd_wrap #(.LO(8'h00), .HI(8'h99), .RST(8'h00)) u_year (
      .clk(clk), .rst_n(rst_n), .inc(c_year), .ld(ld_vec[A_YEAR]),
      .ld_val(wr_data), .q(year_q), .carry(c_unused));

   always_comb begin
      case (rd_addr)
         A_SEC:   rd_data = sec_q;
         A_MIN:   rd_data = min_q;
         A_HOUR:  rd_data = hour_q;
         A_DATE:  rd_data = date_q;
         A_MONTH: rd_data = month_q;
         A_YEAR:  rd_data = year_q;
         A_DOW:   rd_data = {5'b00000, dow_q};
         default: rd_data = 8'h00;
      endcase
   end

   // R11: a write to another register leaves the seconds untouched
   p_write_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != A_SEC) |=> (sec_q == $past(sec_q)));
   // R10: a write lands in its register on the next cycle
   p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_MONTH) |=> (month_q == $past(wr_data)));
endmodule

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
   localparam int DIV = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_in = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [2:0] rd_addr = 3'd0;
   logic [7:0] rd_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bcd_rtc_core #(.TICKS_PER_SEC(DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

   function automatic logic [7:0] bcd(input int v);
      return 8'((v / 10) * 16 + (v % 10));
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick1();
      @(negedge clk);
      tick_in = 1'b1;
      @(negedge clk);
      tick_in = 1'b0;
   endtask

   task automatic sec1();
      repeat (DIV) tick1();
   endtask

   task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
      wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, v2, v3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, v); chk("R1 sec", v, 8'h00);
      rd(3'd1, v); chk("R1 min", v, 8'h00);
      rd(3'd2, v); chk("R1 hour", v, 8'h12);
      rd(3'd3, v); chk("R1 date", v, 8'h01);
      rd(3'd4, v); chk("R1 month", v, 8'h01);
      rd(3'd5, v); chk("R1 year", v, 8'h00);
      rd(3'd6, v); chk("R1 dow", v, 8'h00);
      rd(3'd7, v); chk("R10 unused addr", v, 8'h00);

      // R10 write and read back each register
      for (int a = 0; a < 7; a++) begin
         logic [7:0] d;
         d = (a == 6) ? 8'h05 : (a == 2) ? 8'h87 : bcd(a + 11);
         wr(3'(a), d);
         rd(3'(a), v); chk("R10 readback", v, d);
      end

      // R3 seconds and minutes over two minutes
      set_hms(8'h80, 8'h00, 8'h00);
      for (int i = 1; i <= 120; i++) begin
         sec1();
         rd(3'd0, v);  chk("R3 sec", v, bcd(i % 60));
         rd(3'd1, v2); chk("R3 min", v2, bcd(i / 60));
      end

      // R2 phase and phase reset
      wr(3'd0, 8'h10);
      repeat (DIV - 1) tick1();
      rd(3'd0, v); chk("R2 before last tick", v, 8'h10);
      tick1();
      rd(3'd0, v); chk("R2 full second", v, 8'h11);
      tick1();
      wr(3'd0, 8'h20);
      repeat (DIV - 1) tick1();
      rd(3'd0, v); chk("R2 phase cleared", v, 8'h20);
      tick1();
      rd(3'd0, v); chk("R2 after clear", v, 8'h21);

      // R11 write collides with a second boundary
      repeat (DIV - 1) tick1();
      @(negedge clk);
      tick_in = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h07;
      @(negedge clk);
      tick_in = 1'b0; wr_en = 1'b0;
      rd(3'd0, v);  chk("R11 sec held", v, 8'h21);
      rd(3'd1, v2); chk("R11 min written", v2, 8'h07);
      sec1();
      rd(3'd0, v); chk("R11 next second", v, 8'h22);

      // R4 full 24-hour sweep
      for (int h = 0; h < 24; h++) begin
         wr(3'd3, 8'h05);
         set_hms(8'h80 | bcd(h), 8'h59, 8'h59);
         sec1();
         rd(3'd2, v);  chk("R4 hour", v, 8'h80 | bcd((h + 1) % 24));
         rd(3'd1, v2); chk("R3 min wrap", v2, 8'h00);
         rd(3'd3, v3); chk("R4 date", v3, (h == 23) ? 8'h06 : 8'h05);
      end

      // R5 full 12-hour sweep, AM and PM
      for (int p = 0; p < 2; p++) begin
         for (int k = 0; k < 12; k++) begin
            int hv, nv, np;
            hv = (k == 0) ? 12 : k;
            nv = (hv == 12) ? 1 : hv + 1;
            np = (hv == 11) ? 1 - p : p;
            wr(3'd3, 8'h05);
            wr(3'd6, 8'h02);
            set_hms(8'(p * 32) | bcd(hv), 8'h59, 8'h59);
            sec1();
            rd(3'd2, v);  chk("R5 hour", v, 8'(np * 32) | bcd(nv));
            rd(3'd3, v2); chk("R5 date", v2, (hv == 11 && p == 1) ? 8'h06 : 8'h05);
            rd(3'd6, v3); chk("R9 dow step", v3, (hv == 11 && p == 1) ? 8'h03 : 8'h02);
         end
      end

      // R6 / R9 / R8 month lengths in a plain and a leap year
      for (int yi = 0; yi < 2; yi++) begin
         int yr;
         yr = (yi == 0) ? 21 : 24;
         for (int m = 1; m <= 12; m++) begin
            int last, steps, maxd;
            last = (m == 2) ? ((yr % 4 == 0) ? 29 : 28) :
                   (m == 4 || m == 6 || m == 9 || m == 11) ? 30 : 31;
            wr(3'd5, bcd(yr));
            wr(3'd4, bcd(m));
            wr(3'd3, 8'h28);
            wr(3'd6, 8'h00);
            steps = 0; maxd = 28;
            for (int d = 0; d < 5; d++) begin
               set_hms(8'hA3, 8'h59, 8'h59);
               sec1();
               steps++;
               rd(3'd3, v);
               if (v == 8'h01) break;
               maxd = (v[7:4] * 10) + v[3:0];
            end
            chk(m == 2 ? "R7 feb length" : "R6 month length", bcd(maxd), bcd(last));
            rd(3'd4, v);  chk("R6 month step", v, bcd(m == 12 ? 1 : m + 1));
            rd(3'd6, v2); chk("R9 dow count", v2, 8'(steps % 7));
            rd(3'd5, v3); chk("R8 year step", v3, bcd(m == 12 ? yr + 1 : yr));
         end
      end

      // R7 February for every year
      for (int y = 0; y < 100; y++) begin
         wr(3'd5, bcd(y));
         wr(3'd4, 8'h02);
         wr(3'd3, 8'h28);
         set_hms(8'hA3, 8'h59, 8'h59);
         sec1();
         rd(3'd3, v);  chk("R7 leap date", v, (y % 4 == 0) ? 8'h29 : 8'h01);
         rd(3'd4, v2); chk("R7 leap month", v2, (y % 4 == 0) ? 8'h02 : 8'h03);
      end

      // R8 century wrap of the two-digit year, via 12-hour 11 PM
      wr(3'd5, 8'h99);
      wr(3'd4, 8'h12);
      wr(3'd3, 8'h31);
      set_hms(8'h31, 8'h59, 8'h59);
      sec1();
      rd(3'd5, v);  chk("R8 year wrap", v, 8'h00);
      rd(3'd4, v2); chk("R8 month wrap", v2, 8'h01);
      rd(3'd3, v3); chk("R8 date wrap", v3, 8'h01);
      rd(3'd2, v);  chk("R5 midnight", v, 8'h12);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule